// File: doc/BRIEF.md
# Clock output gating controller

This block decides, for each buffered clock output pair, whether the pair toggles or sits parked with both legs low. It merges a power-good / power-down input, per-output active-low enable pins, per-output enable bits held in a small configuration register, a PLL lock indication, and a PLL mode chosen from a tri-level strap. The strap's electrical decode happens elsewhere. It arrives here as a 2-bit level code.

Each output pair is produced in logic at half the rate of `clk`. The true leg goes high for exactly one `clk` period per output cycle. While the pair runs, the complement leg is the inverse of the true leg. The run request for each output passes through a synchroniser clocked by the same clock that forms the output. The pair only parks after its true leg has fallen. The controller also reports the effective PLL mode as two decoded flags and as a 2-bit readback code. A configuration write can override the strapped mode.

The strap is captured once, on the first high level of the power-good input after reset. A later low level on that input parks every output. Each high level after that resumes operation with the mode captured at first start.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While the synchronised power-good input is low, both legs of every output are low. After `pwrgd_pd` falls, all legs are low no later than the third rising `clk` edge, and they stay low until power-good returns.
- R2: With power good, the PLL clock usable and the enable bit for an output at 1, that output runs exactly when its `oe_n` pin is 0. A running true leg is high on alternate `clk` cycles, which gives 5 high samples in any 10 consecutive cycles.
- R3: An output enable bit of 0 (written through `cfg_oe`, bit i for output i) keeps that output at low/low whatever its `oe_n` pin does.
- R4: The mode strap `mode_pin` is sampled only on the first cycle in which the synchronised power-good is high after reset. Later changes of the strap have no effect, including across power-down and power-up cycles.
- R5: Level codes decode as 2'b00 to PLL low bandwidth (readback 2'b00), 2'b01 to bypass (readback 2'b01) and 2'b11 to PLL high bandwidth (readback 2'b11). The unused code 2'b10 is treated as bypass. `mode_rb` never shows 2'b10.
- R6: While the software-mode bit (`cfg_sw_mode`) is 1, the effective mode is taken from the register mode field (`cfg_mode`, same encoding as R5). While the bit is 0, the captured strap mode applies.
- R7: Outside bypass mode, outputs stay parked while `pll_lock` is low. In bypass mode, outputs run regardless of `pll_lock`.
- R8: An output parked by its enable pin shows its first true-leg high at the third rising edge after `oe_n` falls. After `oe_n` rises, both legs are low by the fourth rising edge. Both delays lie within 1 to 3 output cycles.
- R9: The true leg is never high for two consecutive `clk` cycles. Stopping never truncates a high phase.
- R10: The true and complement legs are never high together. When parked, the complement leg is low and not the inverse of the true leg.
- R11: After reset, all legs are low, both enable bits are 1, the software-mode bit is 0, and the captured mode is bypass (readback 2'b01) until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from which the outputs are formed |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwrgd_pd | input | 1 | Power-good on first high level, power-down while low |
| oe_n | input | NCH | Per-output active-low enable pins |
| mode_pin | input | 2 | Tri-level strap level code (00 low, 01 mid, 11 high) |
| pll_lock | input | 1 | PLL lock indication |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_oe | input | NCH | Per-output enable bits to write |
| cfg_sw_mode | input | 1 | Software-mode bit to write |
| cfg_mode | input | 2 | Register mode field to write |
| clk_t | output | NCH | True legs of the output pairs |
| clk_c | output | NCH | Complement legs of the output pairs |
| pll_bypass | output | 1 | Effective mode is bypass |
| pll_hibw | output | 1 | Effective mode is high bandwidth |
| mode_rb | output | 2 | Readback code of the effective mode |

## Verification
The in-RTL assertions check on every cycle that a true-leg high lasts a single cycle, that the two legs are never high together, that a power-down parks every leg one edge later, that the captured strap never changes once started, and that the readback code is always legal. Other behaviour depends on a scenario and is shown only by the bench. This includes the exact start and stop latencies, that a stale strap is ignored after a power cycle, the software mode override, the lock blocking and its bypass exception, and the decode of the unused strap code. The bench compares every cycle against a behavioural model and also runs targeted checks for each of these.

// File: rtl/cog_pkg.sv
package cog_pkg;

  typedef enum logic [1:0] {
    PM_LOBW   = 2'b00,
    PM_BYPASS = 2'b01,
    PM_HIBW   = 2'b11
  } pll_mode_e;

  // Level code to mode; the unused code falls back to the mid (bypass) level.
  function automatic pll_mode_e level_to_mode(input logic [1:0] lvl);
    pll_mode_e m;
    case (lvl)
      2'b00:   m = PM_LOBW;
      2'b11:   m = PM_HIBW;
      default: m = PM_BYPASS;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cog_sync_bit.sv
module cog_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;
  logic [STAGES:0]   shifted;

  always_comb begin
    shifted = {stg_q, d};
    stg_d   = shifted[STAGES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/cog_pwr_seq.sv
module cog_pwr_seq
  import cog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrgd_pd,
  input  logic [1:0] mode_pin,
  output logic       pwr_on,
  output pll_mode_e  pin_mode
);

  logic      pg_s;
  logic      started_q, started_d;
  pll_mode_e pin_mode_q, pin_mode_d;
  logic      capture;

  cog_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pwrgd_pd),
    .q     (pg_s)
  );

  // First high level of power-good captures the strap; later ones only resume.
  always_comb begin
    capture    = pg_s & ~started_q;
    started_d  = started_q | pg_s;
    pin_mode_d = capture ? level_to_mode(mode_pin) : pin_mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q  <= 1'b0;
      pin_mode_q <= PM_BYPASS;
    end else begin
      started_q  <= started_d;
      pin_mode_q <= pin_mode_d;
    end
  end

  assign pwr_on   = pg_s;
  assign pin_mode = pin_mode_q;

  // R4: once started, the captured strap mode never moves.
  p_strap_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(started_q)) |-> $stable(pin_mode_q));

  // R4: power-good high always leaves the sequencer marked as started.
  p_on_marks_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on |=> started_q);

endmodule

// File: rtl/cog_cfg_regs.sv
module cog_cfg_regs #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [NCH-1:0] oe_wdata,
  input  logic           sw_wdata,
  input  logic [1:0]     mode_wdata,
  output logic [NCH-1:0] oe_en,
  output logic           sw_en,
  output logic [1:0]     sw_mode_raw
);

  logic [NCH-1:0] oe_q, oe_d;
  logic           sw_q, sw_d;
  logic [1:0]     mode_q, mode_d;

  always_comb begin
    oe_d   = oe_q;
    sw_d   = sw_q;
    mode_d = mode_q;
    if (wr) begin
      oe_d   = oe_wdata;
      sw_d   = sw_wdata;
      mode_d = mode_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= {NCH{1'b1}};
      sw_q   <= 1'b0;
      mode_q <= 2'b01;
    end else begin
      oe_q   <= oe_d;
      sw_q   <= sw_d;
      mode_q <= mode_d;
    end
  end

  assign oe_en       = oe_q;
  assign sw_en       = sw_q;
  assign sw_mode_raw = mode_q;

  // R3: enable bits change only through a write strobe.
  p_oe_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(oe_q));

endmodule

// File: rtl/cog_chan.sv
module cog_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  input  logic run_req,
  output logic clk_t,
  output logic clk_c
);

  logic run_s;
  logic t_q, t_d;
  logic c_q, c_d;

  cog_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (run_req),
    .q     (run_s)
  );

  // A high phase always completes; parking is only entered from the low phase.
  always_comb begin
    t_d = 1'b0;
    c_d = 1'b0;
    if (!pwr_on) begin
      t_d = 1'b0;
      c_d = 1'b0;
    end else if (t_q) begin
      t_d = 1'b0;
      c_d = 1'b1;
    end else if (run_s) begin
      t_d = 1'b1;
      c_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      t_q <= t_d;
      c_q <= c_d;
    end
  end

  assign clk_t = t_q;
  assign clk_c = c_q;

  p_no_runt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_t |=> !clk_t);

  p_legs_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_t && clk_c));

  p_pd_parks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (!clk_t && !clk_c));

endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import cog_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwrgd_pd,
  input  logic [NCH-1:0] oe_n,
  input  logic [1:0]     mode_pin,
  input  logic           pll_lock,
  input  logic           cfg_wr,
  input  logic [NCH-1:0] cfg_oe,
  input  logic           cfg_sw_mode,
  input  logic [1:0]     cfg_mode,
  output logic [NCH-1:0] clk_t,
  output logic [NCH-1:0] clk_c,
  output logic           pll_bypass,
  output logic           pll_hibw,
  output logic [1:0]     mode_rb
);

  logic           rst_sync_n;
  logic           pwr_on;
  pll_mode_e      pin_mode;
  pll_mode_e      eff_mode;
  logic [NCH-1:0] oe_en;
  logic           sw_en;
  logic [1:0]     sw_mode_raw;
  logic           clock_ok;
  logic [NCH-1:0] run_req;

  cog_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  cog_pwr_seq #(.SYNC_STAGES(SYNC_STAGES)) u_pwr_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwrgd_pd (pwrgd_pd),
    .mode_pin (mode_pin),
    .pwr_on   (pwr_on),
    .pin_mode (pin_mode)
  );

  cog_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr          (cfg_wr),
    .oe_wdata    (cfg_oe),
    .sw_wdata    (cfg_sw_mode),
    .mode_wdata  (cfg_mode),
    .oe_en       (oe_en),
    .sw_en       (sw_en),
    .sw_mode_raw (sw_mode_raw)
  );

  always_comb begin
    eff_mode   = sw_en ? level_to_mode(sw_mode_raw) : pin_mode;
    pll_bypass = (eff_mode == PM_BYPASS);
    pll_hibw   = (eff_mode == PM_HIBW);
    mode_rb    = eff_mode;
    clock_ok   = pll_bypass | pll_lock;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign run_req[ch] = pwr_on & oe_en[ch] & ~oe_n[ch] & clock_ok;

    cog_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pwr_on  (pwr_on),
      .run_req (run_req[ch]),
      .clk_t   (clk_t[ch]),
      .clk_c   (clk_c[ch])
    );
  end

  p_rb_legal_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_rb != 2'b10);

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(pll_bypass && pll_hibw));

endmodule

// File: tb/tb_clkout_gate_ctrl.sv
module tb_clkout_gate_ctrl;

  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           pwrgd_pd;
  logic [NCH-1:0] oe_n;
  logic [1:0]     mode_pin;
  logic           pll_lock;
  logic           cfg_wr;
  logic [NCH-1:0] cfg_oe;
  logic           cfg_sw_mode;
  logic [1:0]     cfg_mode;
  logic [NCH-1:0] clk_t, clk_c;
  logic           pll_bypass, pll_hibw;
  logic [1:0]     mode_rb;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  clkout_gate_ctrl #(.NCH(NCH), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pwrgd_pd(pwrgd_pd), .oe_n(oe_n),
    .mode_pin(mode_pin), .pll_lock(pll_lock), .cfg_wr(cfg_wr),
    .cfg_oe(cfg_oe), .cfg_sw_mode(cfg_sw_mode), .cfg_mode(cfg_mode),
    .clk_t(clk_t), .clk_c(clk_c), .pll_bypass(pll_bypass),
    .pll_hibw(pll_hibw), .mode_rb(mode_rb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic logic [1:0] lvl_code(input logic [1:0] l);
    if (l == 2'b00) return 2'b00;
    if (l == 2'b11) return 2'b11;
    return 2'b01;
  endfunction

  int         m_rst_cnt = 0;
  bit         m_pg[$];
  bit         m_started = 0;
  logic [1:0] m_pin = 2'b01;
  logic [1:0] m_oe = 2'b11;
  bit         m_sw = 0;
  logic [1:0] m_rmode = 2'b01;
  bit         m_req[NCH][$];
  bit         m_t[NCH];
  bit         m_c[NCH];

  function automatic logic [1:0] m_eff();
    return m_sw ? lvl_code(m_rmode) : m_pin;
  endfunction

  task automatic model_reset();
    m_pg = '{0, 0};
    m_started = 0; m_pin = 2'b01; m_oe = 2'b11; m_sw = 0; m_rmode = 2'b01;
    for (int i = 0; i < NCH; i++) begin
      m_req[i] = '{0, 0}; m_t[i] = 0; m_c[i] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_rst_cnt = 0;
      model_reset();
    end else if (m_rst_cnt < 2) begin
      m_rst_cnt++;
    end else begin
      bit pg_now;
      bit byp;
      pg_now = m_pg[1];
      byp = (m_eff() == 2'b01);
      for (int i = 0; i < NCH; i++) begin
        bit go;
        bit req;
        go = m_req[i][1];
        req = pg_now && m_oe[i] && !oe_n[i] && (byp || pll_lock);
        if (!pg_now)   begin m_t[i] = 0; m_c[i] = 0; end
        else if (m_t[i]) begin m_t[i] = 0; m_c[i] = 1; end
        else if (go)   begin m_t[i] = 1; m_c[i] = 0; end
        else           begin m_t[i] = 0; m_c[i] = 0; end
        m_req[i].push_front(req);
        void'(m_req[i].pop_back());
      end
      if (pg_now && !m_started) begin
        m_started = 1;
        m_pin = lvl_code(mode_pin);
      end
      m_pg.push_front(pwrgd_pd);
      void'(m_pg.pop_back());
      if (cfg_wr) begin
        m_oe = cfg_oe; m_sw = cfg_sw_mode; m_rmode = cfg_mode;
      end
    end
  end

  // Every-cycle comparison, sampled away from the active edge.
  logic [NCH-1:0] prev_t = '0;
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      for (int i = 0; i < NCH; i++) begin
        check(clk_t[i] == m_t[i], $sformatf("R2 model true leg ch%0d", i), clk_t[i], m_t[i]);
        check(clk_c[i] == m_c[i], $sformatf("R10 model comp leg ch%0d", i), clk_c[i], m_c[i]);
        check(!(prev_t[i] && clk_t[i]), $sformatf("R9 double high ch%0d", i), 1, 0);
        check(!(clk_t[i] && clk_c[i]), $sformatf("R10 both legs high ch%0d", i), 1, 0);
      end
      check(mode_rb == m_eff(), "R6 model readback", mode_rb, m_eff());
    end
    prev_t = clk_t;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] strap);
    @(negedge clk);
    cmp_en = 1'b0;
    rst_n = 1'b0; pwrgd_pd = 1'b0; mode_pin = strap;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    cmp_en = 1'b1;
  endtask

  task automatic cfg_write(input logic [1:0] oe, input bit sw, input logic [1:0] md);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_oe = oe; cfg_sw_mode = sw; cfg_mode = md;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic count_highs(input int ch, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (clk_t[ch]) hi++;
    end
  endtask

  task automatic expect_parked(input int ch, input int n, input string tag);
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (clk_t[ch] || clk_c[ch]) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int hi;
    int n;
    rst_n = 1'b1; pwrgd_pd = 1'b0; oe_n = '0; mode_pin = 2'b11; pll_lock = 1'b0;
    cfg_wr = 1'b0; cfg_oe = '0; cfg_sw_mode = 1'b0; cfg_mode = 2'b00;

    do_reset(2'b11);
    check(clk_t == '0 && clk_c == '0, "R11 legs low after reset", {clk_t, clk_c}, 0);
    check(mode_rb == 2'b01, "R11 readback bypass before start", mode_rb, 1);
    expect_parked(0, 5, "R4 outputs parked before first power-good");

    // First start: strap high -> high bandwidth.
    pll_lock = 1'b1; pwrgd_pd = 1'b1;
    wait_cyc(10);
    check(mode_rb == 2'b11, "R5 strap high gives readback 11", mode_rb, 3);
    check(pll_hibw == 1'b1 && pll_bypass == 1'b0, "R5 high bandwidth flags", {pll_hibw, pll_bypass}, 2);
    for (int ch = 0; ch < NCH; ch++) begin
      count_highs(ch, 10, hi);
      check(hi == 5, $sformatf("R11 enable bit defaults let ch%0d run (R2 rate)", ch), hi, 5);
    end

    // Strap change after start is ignored.
    mode_pin = 2'b00;
    wait_cyc(6);
    check(mode_rb == 2'b11, "R4 strap change after start ignored", mode_rb, 3);

    // Pin disable of one output.
    oe_n[1] = 1'b1;
    wait_cyc(6);
    expect_parked(1, 6, "R2 pin high parks ch1");
    count_highs(0, 10, hi);
    check(hi == 5, "R2 ch0 unaffected by ch1 pin", hi, 5);

    // Start latency.
    @(negedge clk);
    oe_n[1] = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!clk_t[1] && n < 20);
    check(n == 3, "R8 start latency in clk edges", n, 3);

    // Stop latency.
    wait_cyc(3);
    @(negedge clk);
    oe_n[1] = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while ((clk_t[1] || clk_c[1]) && n < 20);
    check(n <= 4, "R8 stop latency in clk edges", n, 4);
    expect_parked(1, 4, "R8 stays parked after stop");
    oe_n[1] = 1'b0;

    // Register bit overrides the pin.
    cfg_write(2'b10, 1'b0, 2'b01);
    wait_cyc(6);
    expect_parked(0, 8, "R3 enable bit 0 parks ch0 with pin low");
    count_highs(1, 10, hi);
    check(hi == 5, "R3 ch1 still runs", hi, 5);
    cfg_write(2'b11, 1'b0, 2'b01);
    wait_cyc(6);
    count_highs(0, 10, hi);
    check(hi == 5, "R3 ch0 resumes after bit set", hi, 5);

    // Lock blocks outputs outside bypass.
    pll_lock = 1'b0;
    wait_cyc(6);
    expect_parked(0, 6, "R7 no lock parks ch0 in high bandwidth");
    expect_parked(1, 2, "R7 no lock parks ch1 in high bandwidth");

    // Software override to bypass: runs without lock.
    cfg_write(2'b11, 1'b1, 2'b01);
    wait_cyc(6);
    check(mode_rb == 2'b01 && pll_bypass, "R6 software bypass readback", mode_rb, 1);
    count_highs(0, 10, hi);
    check(hi == 5, "R7 bypass runs without lock", hi, 5);

    cfg_write(2'b11, 1'b1, 2'b00);
    wait_cyc(6);
    check(mode_rb == 2'b00 && !pll_bypass && !pll_hibw, "R6 software low bandwidth", mode_rb, 0);
    expect_parked(1, 6, "R7 software low bandwidth without lock parks");

    cfg_write(2'b11, 1'b0, 2'b00);
    wait_cyc(3);
    check(mode_rb == 2'b11, "R6 software bit 0 restores strap mode", mode_rb, 3);
    pll_lock = 1'b1;
    wait_cyc(8);

    // Power-down and resume.
    @(negedge clk);
    pwrgd_pd = 1'b0;
    wait_cyc(3);
    check(clk_t == '0 && clk_c == '0, "R1 legs low by third edge", {clk_t, clk_c}, 0);
    expect_parked(0, 6, "R1 ch0 held low in power-down");
    check(clk_t[1] == 1'b0 && clk_c[1] == 1'b0, "R1 ch1 held low", clk_t[1], 0);
    mode_pin = 2'b01;
    pwrgd_pd = 1'b1;
    wait_cyc(10);
    check(mode_rb == 2'b11, "R4 resume keeps first captured mode", mode_rb, 3);
    count_highs(1, 10, hi);
    check(hi == 5, "R1 outputs resume after power-good", hi, 5);

    // Unused strap code and low strap.
    do_reset(2'b10);
    pwrgd_pd = 1'b1;
    wait_cyc(10);
    check(mode_rb == 2'b01 && pll_bypass, "R5 code 10 treated as bypass", mode_rb, 1);

    do_reset(2'b00);
    pll_lock = 1'b0;
    pwrgd_pd = 1'b1;
    wait_cyc(10);
    check(mode_rb == 2'b00 && !pll_bypass && !pll_hibw, "R5 strap low gives readback 00", mode_rb, 0);
    expect_parked(0, 4, "R7 low bandwidth waits for lock");
    pll_lock = 1'b1;
    wait_cyc(6);
    count_highs(0, 10, hi);
    check(hi == 5, "R7 runs once locked", hi, 5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule